// File: doc/BRIEF.md
# Serial Receiver Status and Interrupt Unit

This block sits between a serial receive shifter and the processor. It holds the receive data buffer, the overrun, parity and framing error flags, and the completion flags. It also holds three interrupt enables and a two-bit priority field. From these it drives one registered interrupt request with a priority level. The shifter reports each finished character with a one-cycle pulse. That pulse carries the character, the sampled stop bit and the parity check result. Software acknowledges events through write-one-to-clear strobes.

Overrun detection depends on the operating mode. In asynchronous mode, software must re-arm reception with a trigger write before every character. In clock-synchronous slave mode, software must read the buffer before the next character arrives. In clock-synchronous master mode, the shifter only runs when software asks it to, so overrun cannot occur.

Top module: `rx_status_irq`

## Requirements
- R1: After reset, all error flags, both completion flags, all three interrupt enables, the priority field, `irq_req` and `irq_level` are 0.
- R2: On a character pulse with `rx_en`=1, the buffer takes `rx_data` on the next cycle (line high stored as 1). In asynchronous mode (`mode`=00) with `seven_bit`=1, buffer bit 7 is 0.
- R3: In asynchronous mode, the overrun flag (`err_flags[0]`) sets when a character completes and no trigger write has occurred since the previous character, or since receive was enabled. A trigger write in the same cycle as the character counts.
- R4: In slave mode (`mode`=10), the overrun flag sets when a character completes while the previous one is still unread. A read strobe in the same cycle as the character counts as reading the previous one.
- R5: In master mode (`mode`=01, and the unused code 11), the overrun flag never sets.
- R6: In asynchronous mode, a character with stop bit 0 sets the framing flag (`err_flags[2]`). A character with `parity_err`=1 sets the parity flag (`err_flags[1]`). Neither flag sets in the synchronous modes.
- R7: A 1 in bit i of `err_clr` clears error flag i, and a 0 leaves it alone. If a set and a clear of the same flag occur in the same cycle, the set wins.
- R8: While `rx_en`=0, all three error flags read 0 from the next cycle on.
- R9: The completion flags behave as follows:
  - `rx_cmp_flag` sets on a character pulse with `rx_en`=1.
  - `tx_cmp_flag` sets on `tx_done`.
  - Bit 0 of `cmp_clr` clears `rx_cmp_flag` and bit 1 clears `tx_cmp_flag`, with set winning over clear.
- R10: On `cfg_we`, `ie_q` takes `cfg_ie` and `prio_q` takes `cfg_prio`, and both read back. The enable bits are: bit 0 for error, bit 1 for receive complete, bit 2 for transmit complete.
- R11: `irq_req` is registered. It goes to 1 one cycle after both of these hold: some flag is set whose enable is 1 (any error flag, `rx_cmp_flag`, `tx_cmp_flag`), and `prio_q` is nonzero. `irq_level` equals `prio_q` when a request is raised and 0 otherwise. Flags latch even while their enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | 00 async, 01 sync master, 10 sync slave, 11 treated as master |
| seven_bit | input | 1 | Async 7-bit character length |
| rx_done | input | 1 | Character complete pulse |
| rx_data | input | 8 | Received character |
| stop_bit | input | 1 | Sampled stop bit, valid with rx_done |
| parity_err | input | 1 | Parity mismatch, valid with rx_done |
| trig_wr | input | 1 | Software wrote 1 to receive trigger |
| buf_rd | input | 1 | Software read the receive buffer |
| tx_done | input | 1 | Transmit complete pulse |
| err_clr | input | 3 | Write-1 clear of error flags |
| cmp_clr | input | 2 | Write-1 clear of completion flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ie | input | 3 | Enable values to write |
| cfg_prio | input | 2 | Priority value to write |
| rx_buf | output | 8 | Receive buffer |
| err_flags | output | 3 | {framing, parity, overrun} |
| rx_cmp_flag | output | 1 | Receive complete flag |
| tx_cmp_flag | output | 1 | Transmit complete flag |
| ie_q | output | 3 | Interrupt enables |
| prio_q | output | 2 | Priority field |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Request level, 0 when idle |

## Verification
The bench targets several corner cases, each of which exposes a specific design fault:
- A trigger write or buffer read landing in the same cycle as a character. A design that ignored it would flag a false overrun.
- A flag that is set and cleared in the same cycle. A design that let the clear win would lose the error.
- A mode change to master between characters. A design that kept counting missed triggers would raise overrun in master mode.
- Dropping receive enable while flags are set. A design that did not force the flags low would leave stale errors.
- A zero priority field with enabled factors. A design that did not gate the request on priority would interrupt at level 0.

Flags are also latched with their enables off and the enables turned on later, which checks that factors are captured independently of their enables.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'b00,
    MODE_SMASTER = 2'b01,
    MODE_SSLAVE  = 2'b10,
    MODE_RSVD    = 2'b11
  } rx_mode_e;

  localparam int NUM_ERR = 3;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;

  localparam int NUM_FAC = 3;
  localparam int FAC_ERR = 0;
  localparam int FAC_RX  = 1;
  localparam int FAC_TX  = 2;

  localparam int PRIO_W = 2;
endpackage

// File: rtl/rx_overrun_det.sv
module rx_overrun_det
  import rx_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rx_en,
  input  rx_mode_e mode,
  input  logic     rx_done,
  input  logic     trig_wr,
  input  logic     buf_rd,
  output logic     ovr_evt
);
  logic armed_q;
  logic unread_q;
  logic async_miss;
  logic slave_miss;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      armed_q  <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      if (rx_done) armed_q <= 1'b0;
      else if (trig_wr) armed_q <= 1'b1;
      if (rx_done) unread_q <= 1'b1;
      else if (buf_rd) unread_q <= 1'b0;
    end
  end

  always_comb begin
    async_miss = (mode == MODE_ASYNC) && !armed_q && !trig_wr;
    slave_miss = (mode == MODE_SSLAVE) && unread_q && !buf_rd;
    ovr_evt    = rx_en && rx_done && (async_miss || slave_miss);
  end

  // R3: an async character with no trigger seen since enable is an overrun
  p_async_first_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rx_en) && rx_en && rx_done && mode == MODE_ASYNC && !trig_wr) |-> ovr_evt);
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags
  import rx_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_en,
  input  rx_mode_e           mode,
  input  logic               rx_done,
  input  logic               stop_bit,
  input  logic               parity_err,
  input  logic               ovr_evt,
  input  logic [NUM_ERR-1:0] err_clr,
  output logic [NUM_ERR-1:0] err_q
);
  logic [NUM_ERR-1:0] err_set;
  logic               async_chr;

  always_comb begin
    async_chr        = rx_en && rx_done && (mode == MODE_ASYNC);
    err_set          = '0;
    err_set[ERR_OVR] = ovr_evt;
    err_set[ERR_PAR] = async_chr && parity_err;
    err_set[ERR_FRM] = async_chr && !stop_bit;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || !rx_en) err_q[i] <= 1'b0;
      else if (err_set[i]) err_q[i] <= 1'b1;
      else if (err_clr[i]) err_q[i] <= 1'b0;
    end
  end

  p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> err_q == '0);
  p_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_done && mode == MODE_ASYNC && !stop_bit) |=> err_q[ERR_FRM]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_done && mode == MODE_ASYNC && parity_err && err_clr[ERR_PAR]) |=> err_q[ERR_PAR]);
  p_master_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SMASTER || mode == MODE_RSVD) |=> !$rose(err_q[ERR_OVR]));
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import rx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FAC-1:0] fac,
  input  logic [NUM_FAC-1:0] ie,
  input  logic [PRIO_W-1:0]  prio,
  output logic              irq_req,
  output logic [PRIO_W-1:0]  irq_level
);
  logic req_d;

  always_comb req_d = (|(fac & ie)) && (prio != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      irq_req   <= req_d;
      irq_level <= req_d ? prio : '0;
    end
  end

  p_prio_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (prio == '0) |=> !irq_req);
  p_level_nz_r11: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_level != '0);
  p_masked_r11: assert property (@(posedge clk) disable iff (rst)
    ((fac & ie) == '0) |=> !irq_req);
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq
  import rx_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [1:0]        mode,
  input  logic              seven_bit,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              stop_bit,
  input  logic              parity_err,
  input  logic              trig_wr,
  input  logic              buf_rd,
  input  logic              tx_done,
  input  logic [2:0]        err_clr,
  input  logic [1:0]        cmp_clr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_ie,
  input  logic [1:0]        cfg_prio,
  output logic [DATA_W-1:0] rx_buf,
  output logic [2:0]        err_flags,
  output logic              rx_cmp_flag,
  output logic              tx_cmp_flag,
  output logic [2:0]        ie_q,
  output logic [1:0]        prio_q,
  output logic              irq_req,
  output logic [1:0]        irq_level
);
  localparam int MSB = DATA_W - 1;

  rx_mode_e           mode_e;
  logic               ovr_evt;
  logic [DATA_W-1:0]  data_m;
  logic [NUM_FAC-1:0] fac;

  always_comb begin
    mode_e = rx_mode_e'(mode);
    data_m = rx_data;
    if (mode_e == MODE_ASYNC && seven_bit) data_m[MSB] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rx_en && rx_done) rx_buf <= data_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cmp_flag <= 1'b0;
      tx_cmp_flag <= 1'b0;
      ie_q        <= '0;
      prio_q      <= '0;
    end else begin
      if (rx_en && rx_done) rx_cmp_flag <= 1'b1;
      else if (cmp_clr[0]) rx_cmp_flag <= 1'b0;
      if (tx_done) tx_cmp_flag <= 1'b1;
      else if (cmp_clr[1]) tx_cmp_flag <= 1'b0;
      if (cfg_we) begin
        ie_q   <= cfg_ie;
        prio_q <= cfg_prio;
      end
    end
  end

  rx_overrun_det u_ovr (
    .clk(clk), .rst(rst), .rx_en(rx_en), .mode(mode_e), .rx_done(rx_done),
    .trig_wr(trig_wr), .buf_rd(buf_rd), .ovr_evt(ovr_evt)
  );

  rx_err_flags u_err (
    .clk(clk), .rst(rst), .rx_en(rx_en), .mode(mode_e), .rx_done(rx_done),
    .stop_bit(stop_bit), .parity_err(parity_err), .ovr_evt(ovr_evt),
    .err_clr(err_clr), .err_q(err_flags)
  );

  always_comb begin
    fac          = '0;
    fac[FAC_ERR] = |err_flags;
    fac[FAC_RX]  = rx_cmp_flag;
    fac[FAC_TX]  = tx_cmp_flag;
  end

  rx_irq_gen u_irq (
    .clk(clk), .rst(rst), .fac(fac), .ie(ie_q), .prio(prio_q),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  p_seven_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_done && mode_e == MODE_ASYNC && seven_bit) |=> !rx_buf[MSB]);
  p_rxcmp_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_done) |=> rx_cmp_flag);
endmodule

// File: tb/test_rx_status_irq.sv
module test_rx_status_irq;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLES = 3000;

  logic clk = 1'b0;
  logic rst;
  logic rx_en;
  logic [1:0] mode;
  logic seven_bit, rx_done, stop_bit, parity_err, trig_wr, buf_rd, tx_done;
  logic [7:0] rx_data;
  logic [2:0] err_clr;
  logic [1:0] cmp_clr;
  logic cfg_we;
  logic [2:0] cfg_ie;
  logic [1:0] cfg_prio;
  logic [7:0] rx_buf;
  logic [2:0] err_flags;
  logic rx_cmp_flag, tx_cmp_flag;
  logic [2:0] ie_q;
  logic [1:0] prio_q;
  logic irq_req;
  logic [1:0] irq_level;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [2:0] m_err;
  logic m_armed, m_unread, m_seen, m_rxc, m_txc, m_irq;
  logic [7:0] m_buf;
  logic [2:0] m_ie;
  logic [1:0] m_prio, m_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_irq i_rx_status_irq (
    .clk(clk), .rst(rst), .rx_en(rx_en), .mode(mode), .seven_bit(seven_bit),
    .rx_done(rx_done), .rx_data(rx_data), .stop_bit(stop_bit),
    .parity_err(parity_err), .trig_wr(trig_wr), .buf_rd(buf_rd),
    .tx_done(tx_done), .err_clr(err_clr), .cmp_clr(cmp_clr), .cfg_we(cfg_we),
    .cfg_ie(cfg_ie), .cfg_prio(cfg_prio), .rx_buf(rx_buf),
    .err_flags(err_flags), .rx_cmp_flag(rx_cmp_flag), .tx_cmp_flag(tx_cmp_flag),
    .ie_q(ie_q), .prio_q(prio_q), .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  function automatic logic exp_ovr(input logic [1:0] md, input logic armed,
                                   input logic unread, input logic trg, input logic rd);
    if (md == 2'b00) return !armed && !trg;  // R3
    if (md == 2'b10) return unread && !rd;   // R4
    return 1'b0;                             // R5
  endfunction

  function automatic logic [7:0] exp_buf(input logic [1:0] md, input logic sb,
                                         input logic [7:0] d);
    logic [7:0] r = d;
    if (md == 2'b00 && sb) r[7] = 1'b0;
    return r;
  endfunction

  task automatic model_step();
    logic [2:0] set;
    logic req;
    req = (|({m_txc, m_rxc, |m_err} & m_ie)) && (m_prio != 2'b00);
    if (rst) begin
      m_err = '0; m_armed = 0; m_unread = 0; m_rxc = 0; m_txc = 0;
      m_ie = '0; m_prio = '0; m_irq = 0; m_lvl = '0;
      return;
    end
    m_irq = req;
    m_lvl = req ? m_prio : 2'b00;
    set = '0;
    if (rx_en && rx_done) begin
      set[0] = exp_ovr(mode, m_armed, m_unread, trig_wr, buf_rd);
      set[1] = (mode == 2'b00) && parity_err;
      set[2] = (mode == 2'b00) && !stop_bit;
      m_buf = exp_buf(mode, seven_bit, rx_data);
      m_seen = 1;
    end
    for (int i = 0; i < 3; i++) begin
      if (!rx_en) m_err[i] = 1'b0;
      else if (set[i]) m_err[i] = 1'b1;
      else if (err_clr[i]) m_err[i] = 1'b0;
    end
    if (!rx_en) begin
      m_armed = 0; m_unread = 0;
    end else begin
      if (rx_done) m_armed = 0; else if (trig_wr) m_armed = 1;
      if (rx_done) m_unread = 1; else if (buf_rd) m_unread = 0;
    end
    if (rx_en && rx_done) m_rxc = 1; else if (cmp_clr[0]) m_rxc = 0;
    if (tx_done) m_txc = 1; else if (cmp_clr[1]) m_txc = 0;
    if (cfg_we) begin m_ie = cfg_ie; m_prio = cfg_prio; end
  endtask

  task automatic compare_all();
    chk("R3/R4/R5 overrun", {7'd0, err_flags[0]}, {7'd0, m_err[0]});
    chk("R6/R7/R8 parity", {7'd0, err_flags[1]}, {7'd0, m_err[1]});
    chk("R6/R7/R8 framing", {7'd0, err_flags[2]}, {7'd0, m_err[2]});
    chk("R9 completion", {6'd0, tx_cmp_flag, rx_cmp_flag}, {6'd0, m_txc, m_rxc});
    chk("R10 config", {3'd0, ie_q, prio_q}, {3'd0, m_ie, m_prio});
    chk("R11 irq", {5'd0, irq_req, irq_level}, {5'd0, m_irq, m_lvl});
    if (m_seen) chk("R2 buffer", rx_buf, m_buf);
  endtask

  task automatic idle();
    rx_done = 0; trig_wr = 0; buf_rd = 0; tx_done = 0;
    err_clr = '0; cmp_clr = '0; cfg_we = 0; stop_bit = 1; parity_err = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
    @(negedge clk);
    idle();
  endtask

  task automatic rand_inputs(input logic [1:0] md);
    mode = md;
    rx_en = ($urandom_range(0, 19) != 0);
    seven_bit = $urandom_range(0, 1);
    rx_done = ($urandom_range(0, 3) == 0);
    rx_data = 8'($urandom);
    stop_bit = ($urandom_range(0, 5) != 0);
    parity_err = ($urandom_range(0, 5) == 0);
    trig_wr = ($urandom_range(0, 2) == 0);
    buf_rd = ($urandom_range(0, 2) == 0);
    tx_done = ($urandom_range(0, 7) == 0);
    for (int i = 0; i < 3; i++) err_clr[i] = ($urandom_range(0, 7) == 0);
    for (int i = 0; i < 2; i++) cmp_clr[i] = ($urandom_range(0, 5) == 0);
    cfg_we = ($urandom_range(0, 15) == 0);
    cfg_ie = 3'($urandom);
    cfg_prio = 2'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_seen = 0; m_buf = '0;
    rst = 1; rx_en = 0; mode = 2'b00; seven_bit = 0; rx_data = '0;
    cfg_ie = '0; cfg_prio = '0;
    idle();
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 err", {5'd0, err_flags}, 8'd0);
    chk("R1 irq", {5'd0, irq_req, irq_level}, 8'd0);
    chk("R1 cfg", {1'b0, rx_cmp_flag, tx_cmp_flag, ie_q, prio_q}, 8'd0);
    rst = 0;
    rx_en = 1;
    tick();
    // directed R3: async char without trigger -> overrun; with same-cycle trigger -> none
    mode = 2'b00; seven_bit = 1; rx_data = 8'hFF; rx_done = 1; tick();
    chk("R3 no trigger", {7'd0, err_flags[0]}, 8'd1);
    chk("R2 seven bit", rx_buf, 8'h7F);
    err_clr = 3'b001; tick();
    trig_wr = 1; rx_done = 1; rx_data = 8'hA5; seven_bit = 0; tick();
    chk("R3 same-cycle trigger", {7'd0, err_flags[0]}, 8'd0);
    chk("R2 eight bit", rx_buf, 8'hA5);
    // R7: parity set and clear together -> set wins
    trig_wr = 1; rx_done = 1; parity_err = 1; err_clr = 3'b010; tick();
    chk("R7 set wins", {7'd0, err_flags[1]}, 8'd1);
    // R8: disable clears
    rx_en = 0; tick();
    chk("R8 held low", {5'd0, err_flags}, 8'd0);
    rx_en = 1;
    // R4: slave, read same cycle as next char
    mode = 2'b10; rx_done = 1; tick();
    rx_done = 1; buf_rd = 1; tick();
    chk("R4 read same cycle", {7'd0, err_flags[0]}, 8'd0);
    rx_done = 1; tick();
    chk("R4 unread", {7'd0, err_flags[0]}, 8'd1);
    // R5: master never
    err_clr = 3'b111; tick();
    mode = 2'b01; rx_done = 1; tick(); rx_done = 1; tick();
    chk("R5 master", {7'd0, err_flags[0]}, 8'd0);
    // R11: latched while disabled, then enabled, prio 0 then 3
    cmp_clr = 2'b11; tick();
    tx_done = 1; tick();
    chk("R11 masked", {7'd0, irq_req}, 8'd0);
    cfg_we = 1; cfg_ie = 3'b100; cfg_prio = 2'b00; tick(); tick();
    chk("R11 prio zero", {7'd0, irq_req}, 8'd0);
    cfg_we = 1; cfg_ie = 3'b100; cfg_prio = 2'b11; tick(); tick();
    chk("R11 level", {5'd0, irq_req, irq_level}, 8'h07);
    // random phases across modes
    for (int n = 0; n < CYCLES; n++) begin
      rand_inputs(2'((n / 300) % 4));
      tick();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule